// File: doc/BRIEF.md
# Memory Controller Operating-State Machine

This block is the top-level run-state sequencer of a dynamic memory controller. Software reaches it through a simple register write/read port. A command register takes state-change requests. A status register returns the current operating state. The block then drives two signals for the rest of the controller: an enable for the normal traffic path and a request for the memory to enter low power.

Some registers hold timing parameters, memory geometry or direct memory commands. Writes to them are passed on to the neighbouring register file as one-cycle strobes, and only while the block sits in its configuration state. Such a write at any other time is dropped and sets a sticky error flag.

Pausing comes in two forms. A plain pause stops new accepts and then waits until the traffic path reports that nothing is outstanding. An active pause reports paused at once.

Top module: `memStateFsm`

## Requirements
- R1: After reset the status reads 0 (config), trafficEn and lowPowerReq are low and cfgErr is low.
- R2: A read at offset 0x00 returns the state code in bits [1:0], with 0 = config, 1 = ready, 2 = paused, 3 = low-power, and zeros above. A write to offset 0x00 changes nothing and raises no error.
- R3: A write to offset 0x04 carries a command code in bits [2:0]. Go (0) moves the block from config or paused to ready on that clock edge.
- R4: Sleep (1) is accepted only in ready and enters low-power. Wakeup (2) is accepted only in low-power and returns to ready.
- R5: Pause (3) in ready drops trafficEn after that edge while the status still reads ready. The status becomes paused at the first later edge at which trafficBusy is low.
- R6: Active-pause (7) in ready enters paused on that edge, whatever trafficBusy shows.
- R7: Configure (4) returns to config from paused and is a no-op in config. In ready and low-power it is ignored.
- R8: Codes 5 and 6 are ignored in every state. So is any command not listed for the current state, including every command written while a pause is still draining.
- R9: In config, a write to any offset other than 0x00, 0x04 and 0x08 raises cfgWrEn in the same cycle. A write to 0x08 raises dirCmdEn in the same cycle.
- R10: Outside config, those writes raise neither strobe. cfgErr goes high after the write's edge and stays high until reset.
- R11: trafficEn is high exactly while the state is ready and not draining. lowPowerReq is high exactly in low-power.

Parameters: ADDR_W (12), DATA_W (32), STATUS_OFF (0x00), CMD_OFF (0x04), DIRECT_OFF (0x08).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte offset for reads and writes |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data; status at offset 0x00, zero elsewhere |
| trafficBusy | input | 1 | High while traffic is still outstanding |
| trafficEn | output | 1 | Enable for the normal traffic path |
| lowPowerReq | output | 1 | Request for the memory to enter low power |
| cfgWrEn | output | 1 | Accepted configuration-register write strobe |
| dirCmdEn | output | 1 | Accepted direct-command write strobe |
| cfgErr | output | 1 | Sticky flag for a dropped configuration write |

## Verification
The end of a pause drain and a new command write can land on the same clock edge. The bench arms a pause while trafficBusy is high. It then writes a sleep command in the very cycle that trafficBusy falls. The drain must win: the status has to read paused afterwards and not low-power. A second overlap is a rejected configuration write in a state where cfgErr is already set. That write must raise no strobe and must leave the flag high.

// File: rtl/mem_state_pkg.sv
package mem_state_pkg;

  localparam int CMD_W  = 3;
  localparam int STAT_W = 2;

  typedef enum logic [2:0] {
    OP_CONFIG = 3'd0,
    OP_READY  = 3'd1,
    OP_DRAIN  = 3'd2,
    OP_PAUSED = 3'd3,
    OP_LOWPWR = 3'd4
  } opState_e;

  typedef enum logic [CMD_W-1:0] {
    CMD_GO     = 3'd0,
    CMD_SLEEP  = 3'd1,
    CMD_WAKE   = 3'd2,
    CMD_PAUSE  = 3'd3,
    CMD_CONFIG = 3'd4,
    CMD_RSVD5  = 3'd5,
    CMD_RSVD6  = 3'd6,
    CMD_APAUSE = 3'd7
  } cmdCode_e;

  localparam logic [STAT_W-1:0] ST_CODE_CONFIG = 2'd0;
  localparam logic [STAT_W-1:0] ST_CODE_READY  = 2'd1;
  localparam logic [STAT_W-1:0] ST_CODE_PAUSED = 2'd2;
  localparam logic [STAT_W-1:0] ST_CODE_LOWPWR = 2'd3;

  // strobes from the register datapath to the state control
  typedef struct packed {
    logic     cmdWr;
    cmdCode_e cmdCode;
  } cmdStrobe_t;

  // state summary from the control back to the datapath
  typedef struct packed {
    logic              cfgOpen;
    logic [STAT_W-1:0] statusCode;
  } stateView_t;

endpackage

// File: rtl/memStateCtrl.sv
module memStateCtrl
  import mem_state_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cmdStrobe_t cmdStb,
  input  logic       trafficBusy,
  output stateView_t view,
  output logic       trafficEn,
  output logic       lowPowerReq
);

  opState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      OP_CONFIG: begin
        if (cmdStb.cmdWr && cmdStb.cmdCode == CMD_GO) stateD = OP_READY;
      end
      OP_READY: begin
        if (cmdStb.cmdWr) begin
          unique case (cmdStb.cmdCode)
            CMD_SLEEP:  stateD = OP_LOWPWR;
            CMD_PAUSE:  stateD = OP_DRAIN;
            CMD_APAUSE: stateD = OP_PAUSED;
            default:    stateD = OP_READY;
          endcase
        end
      end
      OP_DRAIN: begin
        // commands are not taken while the drain is in progress
        if (!trafficBusy) stateD = OP_PAUSED;
      end
      OP_PAUSED: begin
        if (cmdStb.cmdWr) begin
          unique case (cmdStb.cmdCode)
            CMD_GO:     stateD = OP_READY;
            CMD_CONFIG: stateD = OP_CONFIG;
            default:    stateD = OP_PAUSED;
          endcase
        end
      end
      OP_LOWPWR: begin
        if (cmdStb.cmdWr && cmdStb.cmdCode == CMD_WAKE) stateD = OP_READY;
      end
      default: stateD = OP_CONFIG;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= OP_CONFIG;
    else       stateQ <= stateD;
  end

  always_comb begin
    unique case (stateQ)
      OP_READY, OP_DRAIN: view.statusCode = ST_CODE_READY;
      OP_PAUSED:          view.statusCode = ST_CODE_PAUSED;
      OP_LOWPWR:          view.statusCode = ST_CODE_LOWPWR;
      default:            view.statusCode = ST_CODE_CONFIG;
    endcase
  end

  assign view.cfgOpen = (stateQ == OP_CONFIG);
  assign trafficEn    = (stateQ == OP_READY);
  assign lowPowerReq  = (stateQ == OP_LOWPWR);

endmodule

// File: rtl/memStateRegs.sv
module memStateRegs
  import mem_state_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter int              DATA_W     = 32,
  parameter logic [ADDR_W-1:0] STATUS_OFF = 'h00,
  parameter logic [ADDR_W-1:0] CMD_OFF    = 'h04,
  parameter logic [ADDR_W-1:0] DIRECT_OFF = 'h08
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  stateView_t        view,
  output cmdStrobe_t        cmdStb,
  output logic              cfgWrEn,
  output logic              dirCmdEn,
  output logic              cfgErr
);

  localparam int PAD_W = DATA_W - STAT_W;

  logic hitStatus, hitCmd, hitDirect, hitCfg;
  logic gatedWr, errSet, errQ;
  logic unusedData;

  assign hitStatus = (regAddr == STATUS_OFF);
  assign hitCmd    = (regAddr == CMD_OFF);
  assign hitDirect = (regAddr == DIRECT_OFF);
  assign hitCfg    = !hitStatus && !hitCmd && !hitDirect;

  assign cmdStb.cmdWr   = regWrEn && hitCmd;
  assign cmdStb.cmdCode = cmdCode_e'(regWrData[CMD_W-1:0]);
  assign unusedData     = ^regWrData[DATA_W-1:CMD_W];

  assign gatedWr  = regWrEn && (hitCfg || hitDirect);
  assign cfgWrEn  = regWrEn && hitCfg && view.cfgOpen;
  assign dirCmdEn = regWrEn && hitDirect && view.cfgOpen;
  assign errSet   = gatedWr && !view.cfgOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       errQ <= 1'b0;
    else if (errSet) errQ <= 1'b1;
  end

  assign cfgErr    = errQ;
  assign regRdData = hitStatus ? {{PAD_W{1'b0}}, view.statusCode} : '0;

endmodule

// File: rtl/memStateFsm.sv
module memStateFsm
  import mem_state_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter int              DATA_W     = 32,
  parameter logic [ADDR_W-1:0] STATUS_OFF = 'h00,
  parameter logic [ADDR_W-1:0] CMD_OFF    = 'h04,
  parameter logic [ADDR_W-1:0] DIRECT_OFF = 'h08
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              trafficBusy,
  output logic              trafficEn,
  output logic              lowPowerReq,
  output logic              cfgWrEn,
  output logic              dirCmdEn,
  output logic              cfgErr
);

  cmdStrobe_t cmdStb;
  stateView_t view;
  logic [STAT_W-1:0] statusCode;

  memStateRegs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STATUS_OFF(STATUS_OFF), .CMD_OFF(CMD_OFF), .DIRECT_OFF(DIRECT_OFF)
  ) u_regs (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .view(view), .cmdStb(cmdStb),
    .cfgWrEn(cfgWrEn), .dirCmdEn(dirCmdEn), .cfgErr(cfgErr)
  );

  memStateCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStb(cmdStb), .trafficBusy(trafficBusy),
    .view(view), .trafficEn(trafficEn), .lowPowerReq(lowPowerReq)
  );

  assign statusCode = view.statusCode;

endmodule

// File: rtl/memStateFsm_chk.sv
module memStateFsm_chk #(
  parameter int              ADDR_W  = 12,
  parameter int              DATA_W  = 32,
  parameter logic [ADDR_W-1:0] CMD_OFF = 'h04
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [1:0]        status,
  input logic              trafficEn,
  input logic              lowPowerReq,
  input logic              cfgWrEn,
  input logic              dirCmdEn,
  input logic              cfgErr
);

  logic cmdWr;
  assign cmdWr = regWrEn && (regAddr == CMD_OFF);

  // R11: traffic path only enabled when status reports ready
  p_traffic_ready_r11: assert property (@(posedge clk) disable iff (!rstN)
    trafficEn |-> status == 2'd1);

  // R11: low-power request only while status reports low-power
  p_lowpwr_state_r11: assert property (@(posedge clk) disable iff (!rstN)
    lowPowerReq |-> status == 2'd3);

  // R9: accepted configuration strobes only in config
  p_cfg_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn || dirCmdEn) |-> status == 2'd0);

  // R10: error flag never clears without reset
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);

  // R8: reserved codes leave a settled state unchanged
  p_reserved_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && (regWrData[2:0] == 3'd5 || regWrData[2:0] == 3'd6) && status != 2'd1)
      |=> $stable(status));

  // R6: active-pause from ready lands in paused at once
  p_apause_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && regWrData[2:0] == 3'd7 && trafficEn) |=> status == 2'd2);

  // R4: sleep from ready raises the low-power request
  p_sleep_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && regWrData[2:0] == 3'd1 && trafficEn) |=> lowPowerReq);

endmodule

bind memStateFsm memStateFsm_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_OFF(CMD_OFF)
) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .status(statusCode), .trafficEn(trafficEn),
  .lowPowerReq(lowPowerReq), .cfgWrEn(cfgWrEn), .dirCmdEn(dirCmdEn),
  .cfgErr(cfgErr)
);

// File: tb/memStateFsm_tb.sv
module memStateFsm_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = 12'h000;
  logic [31:0] regWrData = 32'h0;
  logic [31:0] regRdData;
  logic        trafficBusy = 1'b0;
  logic        trafficEn, lowPowerReq, cfgWrEn, dirCmdEn, cfgErr;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [1:0] st;
    logic       tr, lp, er, chk;
    string      tag;
  } exp_t;

  exp_t q[$];

  always #4 clk = ~clk;

  memStateFsm u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .trafficBusy(trafficBusy),
    .trafficEn(trafficEn), .lowPowerReq(lowPowerReq), .cfgWrEn(cfgWrEn),
    .dirCmdEn(dirCmdEn), .cfgErr(cfgErr)
  );

  function automatic exp_t mk(logic [1:0] st, logic tr, logic lp, logic er,
                              logic chk, string tag);
    exp_t e;
    e.st = st; e.tr = tr; e.lp = lp; e.er = er; e.chk = chk; e.tag = tag;
    return e;
  endfunction

  // monitor: compares the outputs after each edge with the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (trafficEn !== e.tr || lowPowerReq !== e.lp || cfgErr !== e.er ||
            (e.chk && regRdData !== {30'b0, e.st})) begin
          failures++;
          $display("FAIL %s: rd=%h tr=%b lp=%b err=%b expected st=%0d tr=%b lp=%b err=%b",
                   e.tag, regRdData, trafficEn, lowPowerReq, cfgErr,
                   e.st, e.tr, e.lp, e.er);
        end
      end
    end
  end

  // driver: one cycle of stimulus, checks same-cycle strobes, queues the outcome
  task automatic drive(input logic we, input logic [11:0] a, input logic [31:0] d,
                       input logic busy, input logic cs, input logic ds, input exp_t e);
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = d; trafficBusy = busy;
    #1;
    checks++;
    if (cfgWrEn !== cs || dirCmdEn !== ds) begin
      failures++;
      $display("FAIL %s strobes: cfgWrEn=%b dirCmdEn=%b expected %b %b",
               e.tag, cfgWrEn, dirCmdEn, cs, ds);
    end
    q.push_back(e);
  endtask

  // write then status read; both cycles use the same busy level
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic busy,
                    input logic cs, input logic ds, input logic [1:0] st,
                    input logic tr, input logic lp, input logic er, input string tag);
    drive(1'b1, a, d, busy, cs, ds, mk(st, tr, lp, er, 1'b0, tag));
    drive(1'b0, 12'h000, 32'h0, busy, 1'b0, 1'b0, mk(st, tr, lp, er, 1'b1, tag));
  endtask

  task automatic cmd(input logic [2:0] c, input logic busy, input logic [1:0] st,
                     input logic tr, input logic lp, input logic er, input string tag);
    wr(12'h004, {29'b0, c}, busy, 1'b0, 1'b0, st, tr, lp, er, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    checks++;
    if (regRdData !== 32'h0 || trafficEn !== 1'b0 || lowPowerReq !== 1'b0 || cfgErr !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: rd=%h tr=%b lp=%b err=%b expected 0 0 0 0",
               regRdData, trafficEn, lowPowerReq, cfgErr);
    end

    // R9: configuration and direct-command writes open in config
    wr(12'h010, 32'h3D0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R9 cfg write in config");
    wr(12'h008, 32'h80000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, "R9 direct cmd in config");
    // R2: status is read-only
    wr(12'h000, 32'h3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R2 status write ignored");
    // R8: reserved and inapplicable commands in config
    cmd(3'd5, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R8 code5 in config");
    cmd(3'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R8 wakeup in config");
    cmd(3'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R8 sleep in config");
    cmd(3'd4, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R7 configure in config");
    // R3, R11: go to ready
    cmd(3'd0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, "R3 go from config");
    // R7, R8: ignored in ready
    cmd(3'd4, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, "R7 configure ignored in ready");
    cmd(3'd6, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, "R8 code6 in ready");
    // R10: blocked config write sets sticky error
    wr(12'h020, 32'hA, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, "R10 cfg write in ready");
    // R4, R11: sleep and wakeup
    cmd(3'd1, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, "R4 sleep from ready");
    cmd(3'd0, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, "R8 go ignored in low-power");
    cmd(3'd5, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, "R8 code5 in low-power");
    cmd(3'd2, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, "R4 wakeup to ready");
    // R6: active-pause while busy
    cmd(3'd7, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, "R6 active-pause while busy");
    cmd(3'd1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, "R8 sleep ignored in paused");
    cmd(3'd0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, "R3 go from paused");
    // R5: pause waits on drain
    cmd(3'd3, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, "R5 pause draining");
    drive(1'b0, 12'h000, 32'h0, 1'b1, 1'b0, 1'b0, mk(2'd1, 1'b0, 1'b0, 1'b1, 1'b1, "R5 still draining"));
    // drain ends in the same cycle as a sleep write: drain wins (R5, R8)
    cmd(3'd1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, "R5 drain end with sleep write");
    // R7: configure from paused; R10: flag still held
    cmd(3'd4, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, "R7 configure from paused");
    wr(12'h030, 32'h1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, "R9 cfg write after reconfig");
    // R5: pause with nothing outstanding
    cmd(3'd0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, "R3 go again");
    cmd(3'd3, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, "R5 pause idle");
    // R10: direct command blocked while paused, flag stays
    wr(12'h008, 32'h40000, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, "R10 direct cmd in paused");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule